// File: doc/BRIEF.md
# Flash-to-FPGA Serial Bitstream Streamer

This block copies a configuration bitstream from the serial output of a flash device into an FPGA, one bit at a time, over the FPGA's serial configuration data line. The request interface takes a byte count and a start pulse. For every bit, the block first captures the flash output and places it on FPGA data line 0. It then pulses the configuration clock, and after that pulses the flash clock to move the flash on to its next bit. While bits are moving, only data line 0 is driven and the other data lines stay released. The flash command and address setup are done elsewhere before a request is issued.

A request whose size is exactly 512 moves no bits. Instead, the block runs a hand-over sequence so the FPGA can boot from the flash on its own. The sequence first releases the data bus and the configuration clock and deselects the flash. It then drives the program line low and then high, and waits a programmed settling time. Finally, it takes back the configuration clock and selects the flash again.

Every accepted request, including one of size 0 or 512, adds its size to a 32-bit running byte total. Each phase of the clock waveforms lasts a parameter number of system clock cycles (at least one), so the flash clock and the configuration clock can be slowed to suit the attached parts.

Top module: `flash_cfg_relay`

## Requirements
- R1: After reset, the block is idle with busy low and done low, and total_bytes is 0. The configuration clock is driven high (cfg_cclk=1, cfg_cclk_oe=1), flash_sck is low and flash_cs_n is low. cfg_data_oe and cfg_prog_oe are both 0.
- R2: Each request accepted while idle adds req_size to total_bytes; the new total is visible the cycle after the start is accepted. total_bytes changes at no other time.
- R3: A request of N bytes, where N is neither 0 nor 512, gives exactly 8*N rising edges of cfg_cclk and exactly 8*N rising edges of flash_sck.
- R4: Each bit runs four phases of HALF_CYC system cycles each, in this order: cfg_cclk low, cfg_cclk high, flash_sck high, flash_sck low. flash_sck is high only while cfg_cclk is high. A streaming request of N bytes therefore keeps busy high for 32*HALF_CYC*N cycles.
- R5: The bit on cfg_data[0] at each rising edge of cfg_cclk is the flash_dq value captured when that bit's low phase began. The value on cfg_data does not change at that rising edge. Bit k of the stream is therefore the flash output after k flash_sck rising edges.
- R6: A request of size 0 produces no clock edges and never raises busy. It gives a done pulse in the cycle after the start.
- R7: While streaming, cfg_data_oe equals 8'h01 (only bit 0 driven) and flash_cs_n stays low. While idle, cfg_data_oe is 0.
- R8: A request of exactly 512 produces no cfg_cclk or flash_sck edges. Throughout the request, cfg_data_oe=0, cfg_cclk_oe=0 and flash_cs_n=1. The sequence has HALF_CYC release cycles, then cfg_prog_n driven low for HALF_CYC cycles, then driven high for HALF_CYC cycles, then HOLD_CYC cycles with the program line released. Busy lasts 3*HALF_CYC+HOLD_CYC cycles. After that, cfg_cclk_oe=1, cfg_cclk=1 and flash_cs_n=0.
- R9: A start pulse while busy is ignored: total_bytes, the number of clock edges and the length of the running request are unchanged.
- R10: done is a single-cycle pulse in the first idle cycle after a request ends, and busy falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse, accepted only while idle |
| req_size | input | SIZE_W | Byte count of the request; 512 selects hand-over |
| busy | output | 1 | A request is running |
| done | output | 1 | One-cycle pulse when a request ends |
| total_bytes | output | TOTAL_W | Running sum of accepted request sizes |
| flash_dq | input | 1 | Serial data output of the flash |
| flash_sck | output | 1 | Flash serial clock |
| flash_cs_n | output | 1 | Flash select, active low |
| cfg_data | output | BUS_W | FPGA configuration data bus value (bit 0 carries the stream) |
| cfg_data_oe | output | BUS_W | Per-line drive enable for cfg_data |
| cfg_cclk | output | 1 | FPGA configuration clock value |
| cfg_cclk_oe | output | 1 | Drive enable for the configuration clock |
| cfg_prog_n | output | 1 | FPGA program line value, active low |
| cfg_prog_oe | output | 1 | Drive enable for the program line |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a running stream. It must leave the total, the edge counts and the request length untouched. The bench creates this case by issuing a second start with a different size a few cycles into a two-byte request, and then compares every count with what a single request would give. Getting each bit's data right also depends on matching the order of flash clock edges against configuration clock edges. For this, the bench models the flash as a fixed pattern that advances on each flash_sck rise, and checks the value captured at every cfg_cclk rise against the pattern index.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CCLK_LO,
        ST_CCLK_HI,
        ST_FSCK_HI,
        ST_FSCK_LO,
        ST_HO_RELEASE,
        ST_HO_PROG_LO,
        ST_HO_PROG_HI,
        ST_HO_WAIT
    } relay_state_e;

endpackage

// File: rtl/relay_phase_timer.sv
module relay_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/relay_byte_total.sv
module relay_byte_total #(
    parameter int SIZE_W  = 16,
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [SIZE_W-1:0]  add_val,
    output logic [TOTAL_W-1:0] total
);
    logic [TOTAL_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + TOTAL_W'(add_val);
        end
    end

    assign total = sum_q;
endmodule

// File: rtl/flash_cfg_relay.sv
module flash_cfg_relay
    import flash_cfg_pkg::*;
#(
    parameter int SIZE_W        = 16,
    parameter int TOTAL_W       = 32,
    parameter int BUS_W         = 8,
    parameter int HALF_CYC      = 2,
    parameter int HOLD_CYC      = 6,
    parameter int HANDOVER_SIZE = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic [SIZE_W-1:0]  req_size,
    output logic               busy,
    output logic               done,
    output logic [TOTAL_W-1:0] total_bytes,
    input  logic               flash_dq,
    output logic               flash_sck,
    output logic               flash_cs_n,
    output logic [BUS_W-1:0]   cfg_data,
    output logic [BUS_W-1:0]   cfg_data_oe,
    output logic               cfg_cclk,
    output logic               cfg_cclk_oe,
    output logic               cfg_prog_n,
    output logic               cfg_prog_oe
);
    localparam int TMR_MAX = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0]  HALF_LOAD = TMR_W'(HALF_CYC - 1);
    localparam logic [TMR_W-1:0]  HOLD_LOAD = TMR_W'(HOLD_CYC - 1);
    localparam logic [SIZE_W-1:0] HO_SIZE   = SIZE_W'(HANDOVER_SIZE);

    generate
        if (HALF_CYC < 1) begin : g_bad_half
            $error("HALF_CYC must be at least 1");
        end
        if (HOLD_CYC < 3) begin : g_bad_hold
            $error("HOLD_CYC must exceed two cycles");
        end
    endgenerate

    typedef struct packed {
        relay_state_e      state;
        logic [2:0]        bit_idx;
        logic [SIZE_W-1:0] bytes_left;
        logic              d0;
        logic              done;
    } relay_regs_t;

    relay_regs_t       r_q, r_d;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              add_en;

    relay_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    relay_byte_total #(.SIZE_W(SIZE_W), .TOTAL_W(TOTAL_W)) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (add_en),
        .add_val (req_size),
        .total   (total_bytes)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = HALF_LOAD;
        add_en   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_start) begin
                    add_en = 1'b1;
                    if (req_size == HO_SIZE) begin
                        r_d.state = ST_HO_RELEASE;
                        tmr_load  = 1'b1;
                    end else if (req_size == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state      = ST_CCLK_LO;
                        r_d.bit_idx    = 3'd7;
                        r_d.bytes_left = req_size;
                        r_d.d0         = flash_dq;
                        tmr_load       = 1'b1;
                    end
                end
            end
            ST_CCLK_LO: if (tmr_exp) begin
                r_d.state = ST_CCLK_HI;
                tmr_load  = 1'b1;
            end
            ST_CCLK_HI: if (tmr_exp) begin
                r_d.state = ST_FSCK_HI;
                tmr_load  = 1'b1;
            end
            ST_FSCK_HI: if (tmr_exp) begin
                r_d.state = ST_FSCK_LO;
                tmr_load  = 1'b1;
            end
            ST_FSCK_LO: if (tmr_exp) begin
                if (r_q.bit_idx == 3'd0 && r_q.bytes_left == SIZE_W'(1)) begin
                    r_d.state      = ST_IDLE;
                    r_d.bytes_left = '0;
                    r_d.done       = 1'b1;
                end else begin
                    if (r_q.bit_idx == 3'd0) begin
                        r_d.bytes_left = r_q.bytes_left - 1'b1;
                        r_d.bit_idx    = 3'd7;
                    end else begin
                        r_d.bit_idx = r_q.bit_idx - 1'b1;
                    end
                    r_d.d0    = flash_dq;
                    r_d.state = ST_CCLK_LO;
                    tmr_load  = 1'b1;
                end
            end
            ST_HO_RELEASE: if (tmr_exp) begin
                r_d.state = ST_HO_PROG_LO;
                tmr_load  = 1'b1;
            end
            ST_HO_PROG_LO: if (tmr_exp) begin
                r_d.state = ST_HO_PROG_HI;
                tmr_load  = 1'b1;
            end
            ST_HO_PROG_HI: if (tmr_exp) begin
                r_d.state = ST_HO_WAIT;
                tmr_val   = HOLD_LOAD;
                tmr_load  = 1'b1;
            end
            ST_HO_WAIT: if (tmr_exp) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, bit_idx: 3'd0, bytes_left: '0, d0: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    logic streaming, handing;
    assign streaming = (r_q.state == ST_CCLK_LO) || (r_q.state == ST_CCLK_HI) ||
                       (r_q.state == ST_FSCK_HI) || (r_q.state == ST_FSCK_LO);
    assign handing   = (r_q.state == ST_HO_RELEASE) || (r_q.state == ST_HO_PROG_LO) ||
                       (r_q.state == ST_HO_PROG_HI) || (r_q.state == ST_HO_WAIT);

    assign busy        = (r_q.state != ST_IDLE);
    assign done        = r_q.done;
    assign flash_sck   = (r_q.state == ST_FSCK_HI);
    assign flash_cs_n  = handing;
    assign cfg_data    = {{(BUS_W-1){1'b0}}, r_q.d0};
    assign cfg_data_oe = {{(BUS_W-1){1'b0}}, streaming};
    assign cfg_cclk    = (r_q.state != ST_CCLK_LO);
    assign cfg_cclk_oe = !handing;
    assign cfg_prog_n  = (r_q.state != ST_HO_PROG_LO);
    assign cfg_prog_oe = (r_q.state == ST_HO_PROG_LO) || (r_q.state == ST_HO_PROG_HI);
endmodule

// File: rtl/relay_checker.sv
module relay_checker #(
    parameter int SIZE_W  = 16,
    parameter int TOTAL_W = 32,
    parameter int BUS_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_start,
    input logic [SIZE_W-1:0]  req_size,
    input logic               busy,
    input logic               done,
    input logic [TOTAL_W-1:0] total_bytes,
    input logic               flash_dq,
    input logic               flash_sck,
    input logic               flash_cs_n,
    input logic [BUS_W-1:0]   cfg_data,
    input logic [BUS_W-1:0]   cfg_data_oe,
    input logic               cfg_cclk,
    input logic               cfg_cclk_oe,
    input logic               cfg_prog_n,
    input logic               cfg_prog_oe
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r4_sck_inside_high: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sck |-> (cfg_cclk && cfg_data_oe[0] && !flash_cs_n));

    a_r8_prog_released_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog_oe |-> (!cfg_cclk_oe && flash_cs_n && cfg_data_oe == '0 && busy));

    a_r2_total_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(total_bytes) |-> $past(req_start && !busy));

    a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_start) |=> $stable(total_bytes));

    a_r5_data_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cclk) |-> $stable(cfg_data));
endmodule

bind flash_cfg_relay relay_checker #(
    .SIZE_W  (SIZE_W),
    .TOTAL_W (TOTAL_W),
    .BUS_W   (BUS_W)
) u_chk (.*);

// File: tb/sim_flash_cfg_relay.sv
`timescale 1ns/1ps
module sim_flash_cfg_relay;
    localparam int SIZE_W  = 16;
    localparam int TOTAL_W = 32;
    localparam int BUS_W   = 8;
    localparam int H       = 2;
    localparam int HOLD    = 6;
    localparam logic [63:0] PAT = 64'hA5C3_0F96_3C5A_E71B;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_start = 1'b0;
    logic [SIZE_W-1:0]  req_size = '0;
    logic               busy, done;
    logic [TOTAL_W-1:0] total_bytes;
    logic               flash_dq;
    logic               flash_sck, flash_cs_n;
    logic [BUS_W-1:0]   cfg_data, cfg_data_oe;
    logic               cfg_cclk, cfg_cclk_oe, cfg_prog_n, cfg_prog_oe;

    int checks = 0;
    int errors = 0;
    longint model_total = 0;

    int fidx = 0, cidx = 0, dmis = 0, crise = 0, srise = 0;
    int bad_bus = 0, plo = 0, phi = 0, plo_first = -1, phi_first = -1;

    always #5 clk = ~clk;

    flash_cfg_relay #(
        .SIZE_W(SIZE_W), .TOTAL_W(TOTAL_W), .BUS_W(BUS_W),
        .HALF_CYC(H), .HOLD_CYC(HOLD), .HANDOVER_SIZE(512)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_size(req_size),
        .busy(busy), .done(done), .total_bytes(total_bytes),
        .flash_dq(flash_dq), .flash_sck(flash_sck), .flash_cs_n(flash_cs_n),
        .cfg_data(cfg_data), .cfg_data_oe(cfg_data_oe),
        .cfg_cclk(cfg_cclk), .cfg_cclk_oe(cfg_cclk_oe),
        .cfg_prog_n(cfg_prog_n), .cfg_prog_oe(cfg_prog_oe)
    );

    // flash model: fixed pattern advancing on each serial clock rise
    assign flash_dq = PAT[fidx[5:0]];

    always @(posedge flash_sck) begin
        fidx  = fidx + 1;
        srise = srise + 1;
    end

    always @(posedge cfg_cclk) begin
        crise = crise + 1;
        if (cfg_data_oe[0] === 1'b1) begin
            if (cfg_data[0] !== PAT[cidx[5:0]]) dmis = dmis + 1;
            cidx = cidx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue a request; optional second start at cycle inj_at while busy
    task automatic issue(input int size, input int inj_at, input int inj_size,
                         input bit ho, output int bcyc);
        crise = 0; srise = 0; dmis = 0; bad_bus = 0;
        plo = 0; phi = 0; plo_first = -1; phi_first = -1;
        bcyc = 0;
        @(negedge clk);
        req_start = 1'b1;
        req_size  = SIZE_W'(size);
        @(negedge clk);
        req_start = 1'b0;
        while (busy) begin
            if (ho) begin
                if (cfg_data_oe != '0 || cfg_cclk_oe || !flash_cs_n) bad_bus++;
                if (cfg_prog_oe && !cfg_prog_n) begin
                    if (plo_first < 0) plo_first = bcyc;
                    plo++;
                end
                if (cfg_prog_oe && cfg_prog_n) begin
                    if (phi_first < 0) phi_first = bcyc;
                    phi++;
                end
            end else begin
                if (cfg_data_oe != 8'h01 || flash_cs_n) bad_bus++;
            end
            bcyc++;
            if (bcyc == inj_at) begin
                req_start = 1'b1;
                req_size  = SIZE_W'(inj_size);
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
        end
        req_start = 1'b0;
        check(done === 1'b1, "R10 done at end", longint'(done), 1);
        check(cfg_data_oe == '0, "R7 bus released when idle", longint'(cfg_data_oe), 0);
        @(negedge clk);
        check(done === 1'b0, "R10 done single cycle", longint'(done), 0);
    endtask

    task automatic t_reset;
        check(busy === 1'b0 && done === 1'b0, "R1 idle flags", longint'({busy, done}), 0);
        check(total_bytes === '0, "R1 total zero", longint'(total_bytes), 0);
        check(cfg_cclk === 1'b1 && cfg_cclk_oe === 1'b1 && flash_sck === 1'b0 && flash_cs_n === 1'b0,
              "R1 clock and select", longint'({cfg_cclk, cfg_cclk_oe, flash_sck, flash_cs_n}), 4'b1100);
        check(cfg_data_oe === '0 && cfg_prog_oe === 1'b0, "R1 drives off",
              longint'({cfg_data_oe, cfg_prog_oe}), 0);
    endtask

    task automatic t_stream(input int n);
        int b;
        model_total += n;
        issue(n, -1, 0, 1'b0, b);
        check(b == 32 * H * n, "R4 busy length", b, 32 * H * n);
        check(crise == 8 * n, "R3 cclk rises", crise, 8 * n);
        check(srise == 8 * n, "R3 flash clock rises", srise, 8 * n);
        check(dmis == 0, "R5 streamed bits", dmis, 0);
        check(bad_bus == 0, "R7 bus drive while streaming", bad_bus, 0);
        check(total_bytes == TOTAL_W'(model_total), "R2 total", longint'(total_bytes), model_total);
    endtask

    task automatic t_zero;
        int b;
        issue(0, -1, 0, 1'b0, b);
        check(b == 0, "R6 zero size never busy", b, 0);
        check(crise == 0 && srise == 0, "R6 no clock edges", crise + srise, 0);
        check(total_bytes == TOTAL_W'(model_total), "R2 total after zero", longint'(total_bytes), model_total);
    endtask

    task automatic t_handover;
        int b;
        model_total += 512;
        issue(512, -1, 0, 1'b1, b);
        check(b == 3 * H + HOLD, "R8 hand-over length", b, 3 * H + HOLD);
        check(crise == 0 && srise == 0, "R8 no clock edges", crise + srise, 0);
        check(bad_bus == 0, "R8 released during hand-over", bad_bus, 0);
        check(plo == H && plo_first == H, "R8 program low phase", plo * 100 + plo_first, H * 100 + H);
        check(phi == H && phi_first == 2 * H, "R8 program high phase", phi * 100 + phi_first, H * 100 + 2 * H);
        check(cfg_cclk_oe && cfg_cclk && !flash_cs_n && !cfg_prog_oe, "R8 restored after",
              longint'({cfg_cclk_oe, cfg_cclk, flash_cs_n, cfg_prog_oe}), 4'b1100);
        check(total_bytes == TOTAL_W'(model_total), "R2 total after hand-over", longint'(total_bytes), model_total);
    endtask

    task automatic t_busy_ignore;
        int b;
        model_total += 2;
        issue(2, 5, 7, 1'b0, b);
        check(b == 64 * H, "R9 length unchanged by extra start", b, 64 * H);
        check(crise == 16 && srise == 16, "R9 edge counts unchanged", crise + srise, 32);
        check(total_bytes == TOTAL_W'(model_total), "R9 total ignores extra start",
              longint'(total_bytes), model_total);
        check(dmis == 0, "R5 bits across ignored start", dmis, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream(1);
        t_stream(3);
        t_zero();
        t_handover();
        t_busy_ignore();
        t_stream(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule